// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block decides, every cycle, whether the instruction sitting in decode of a five-stage in-order integer pipeline may advance, and from where each of its two execute operands must be taken. It compares the two source register indices of the decode instruction with the destination indices of the instructions currently in execute and in memory. It then drives a hold signal that freezes the program counter and the fetch/decode register, a bubble signal that turns the next decode/execute entry into a no-op, and a two-bit operand source select for each operand. The datapath registers the selects along with the instruction.

In normal operation only two situations stall the pipeline. The first is a load in execute whose result the decode instruction needs: its data exists only after the memory stage, so one cycle is lost. The second is a multi-cycle multiply that is still busy. Every other register dependency is covered by forwarding. A constant-time mode removes the timing difference between kinds of hazard. In that mode any detected dependency, including one that forwarding would have covered for free, costs the same fixed number of stall cycles. Register 0 is hardwired to zero and never counts as a dependency.

Top module: `hzd_interlock`

## Requirements
- R1: A source index of 0 never produces a stall or a forward: its operand select stays 00 (register file) whatever the execute and memory destinations are.
- R2: A source whose valid flag is low never matches, so it cannot stall or forward.
- R3: In normal mode, a load in execute (write enable high, load flag high, destination non-zero) whose destination equals a valid source of the decode instruction raises hold and bubble in that same cycle.
- R4: In normal mode, a non-load writer in execute matching a valid source sets that operand's select to 10 (from the execute/memory register) and raises no hold.
- R5: A writer in memory matching a valid source sets that operand's select to 01 (from the memory/write-back register) without hold, whether or not it is a load.
- R6: When the execute and memory destinations both match the same source, select 10 wins over 01.
- R7: A destination with write enable low never matches, even when its load flag is set.
- R8: In normal mode, hold and bubble stay high for every cycle in which the multiply busy input is high.
- R9: In constant-time mode (ct_mode high), any hazard (a matching writer in execute or memory, a load-use match, or multiply busy) raises hold and bubble for exactly CT_STALLS consecutive cycles, starting in the cycle it is seen.
- R10: After a constant-time stall has begun, the inputs, including ct_mode, have no effect until it ends: hold stays high for the remaining cycles even if every hazard and the mode disappear.
- R11: Reset (rst_n low) clears a constant-time countdown at once. After reset, hold and bubble are low when no hazard is presented.
- R12: Bubble equals hold in every cycle, and an operand select never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ct_mode | input | 1 | Constant-time stall mode enable |
| dec_rs1 | input | 5 | Decode instruction first source index |
| dec_rs1_vld | input | 1 | First source is used |
| dec_rs2 | input | 5 | Decode instruction second source index |
| dec_rs2_vld | input | 1 | Second source is used |
| ex_rd | input | 5 | Destination index of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | 5 | Destination index of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| mul_busy | input | 1 | Multi-cycle multiply still in progress |
| front_hold | output | 1 | Freeze PC and fetch/decode register |
| dx_bubble | output | 1 | Load a no-op into the decode/execute register |
| opa_sel | output | 2 | First operand source: 00 register file, 01 memory/write-back, 10 execute/memory |
| opb_sel | output | 2 | Second operand source, same encoding |

## Verification
The hardest situation to reach from the ports is a constant-time countdown that must ignore its inputs. That requires a hazard to fire the timer, and then, inside the remaining stall cycles, the hazard must vanish and the mode must be switched off. The bench fires the timer with a plain ALU dependency, which would cost nothing in normal mode. On the next falling edge it clears every input and drops ct_mode, and it checks that hold persists for exactly the remaining cycles. A second run holds the hazard present throughout, to show that the timer re-arms only after a full window. A third asserts reset in the middle of a window.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } opsel_e;
endpackage

// File: rtl/hzd_src_cmp.sv
`timescale 1ns/1ps
module hzd_src_cmp
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          src_vld,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  output logic          ex_hit,
  output logic          mem_hit,
  output logic          load_hit,
  output opsel_e        sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic live;

  always_comb begin
    live     = src_vld && (src != ZERO_REG);
    ex_hit   = live && ex_wen && (ex_rd == src);
    mem_hit  = live && mem_wen && (mem_rd == src);
    load_hit = ex_hit && ex_is_load;
    if (ex_hit && !ex_is_load) begin
      sel = SEL_EXM;
    end else if (mem_hit) begin
      sel = SEL_MWB;
    end else begin
      sel = SEL_RF;
    end
  end
endmodule

// File: rtl/hzd_ct_timer.sv
`timescale 1ns/1ps
module hzd_ct_timer #(
  parameter int STALLS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  localparam int CW = (STALLS > 1) ? $clog2(STALLS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(STALLS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_en = busy || fire;
    if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = RELOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/hzd_interlock.sv
`timescale 1ns/1ps
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter int AW        = 5,
  parameter int CT_STALLS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ct_mode,
  input  logic [AW-1:0] dec_rs1,
  input  logic          dec_rs1_vld,
  input  logic [AW-1:0] dec_rs2,
  input  logic          dec_rs2_vld,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mul_busy,
  output logic          front_hold,
  output logic          dx_bubble,
  output logic [1:0]    opa_sel,
  output logic [1:0]    opb_sel
);
  localparam int NSRC = 2;

  logic [AW-1:0] src     [NSRC];
  logic          src_vld [NSRC];
  logic [NSRC-1:0] ex_hit, mem_hit, load_hit;
  opsel_e        sel     [NSRC];

  assign src[0]     = dec_rs1;
  assign src[1]     = dec_rs2;
  assign src_vld[0] = dec_rs1_vld;
  assign src_vld[1] = dec_rs2_vld;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hzd_src_cmp #(.AW(AW)) u_cmp (
      .src        (src[i]),
      .src_vld    (src_vld[i]),
      .ex_rd      (ex_rd),
      .ex_wen     (ex_wen),
      .ex_is_load (ex_is_load),
      .mem_rd     (mem_rd),
      .mem_wen    (mem_wen),
      .ex_hit     (ex_hit[i]),
      .mem_hit    (mem_hit[i]),
      .load_hit   (load_hit[i]),
      .sel        (sel[i])
    );
  end

  logic load_use, any_hazard, ct_fire, ct_busy, hold;

  always_comb begin
    load_use   = |load_hit;
    any_hazard = (|ex_hit) || (|mem_hit) || mul_busy;
    ct_fire    = ct_mode && !ct_busy && any_hazard;
    hold       = ct_busy || ct_fire || (!ct_mode && (load_use || mul_busy));
  end

  hzd_ct_timer #(.STALLS(CT_STALLS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (ct_fire),
    .busy  (ct_busy)
  );

  assign front_hold = hold;
  assign dx_bubble  = hold;
  assign opa_sel    = sel[0];
  assign opb_sel    = sel[1];
endmodule

// File: rtl/hzd_interlock_chk.sv
`timescale 1ns/1ps
module hzd_interlock_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ct_mode,
  input logic [AW-1:0] dec_rs1,
  input logic          dec_rs1_vld,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          mul_busy,
  input logic          ct_busy,
  input logic          front_hold,
  input logic          dx_bubble,
  input logic [1:0]    opa_sel,
  input logic [1:0]    opb_sel
);
  logic a_ld, a_ex, a_mem;
  assign a_ld  = dec_rs1_vld && (dec_rs1 != '0) && ex_wen && ex_is_load && (ex_rd == dec_rs1);
  assign a_ex  = dec_rs1_vld && (dec_rs1 != '0) && ex_wen && !ex_is_load && (ex_rd == dec_rs1);
  assign a_mem = dec_rs1_vld && (dec_rs1 != '0) && mem_wen && (mem_rd == dec_rs1);

  a_r1_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs1 == '0) |-> (opa_sel == 2'b00));
  a_r2_invalid_src: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_rs1_vld |-> (opa_sel == 2'b00));
  a_r3_load_use_holds: assert property (@(posedge clk) disable iff (!rst_n)
    a_ld |-> (front_hold && dx_bubble));
  a_r4_no_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ct_mode && !ct_busy && !mul_busy && !ex_is_load) |-> !front_hold);
  a_r6_young_first: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ex && a_mem) |-> (opa_sel == 2'b10));
  a_r5_mem_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mem && !a_ex && !a_ld) |-> (opa_sel == 2'b01));
  a_r8_mul_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mul_busy |-> front_hold);
  a_r10_countdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ct_busy |-> front_hold);
  a_r12_bubble_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (front_hold == dx_bubble) && (opa_sel != 2'b11) && (opb_sel != 2'b11));
endmodule

bind hzd_interlock hzd_interlock_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ct_mode     (ct_mode),
  .dec_rs1     (dec_rs1),
  .dec_rs1_vld (dec_rs1_vld),
  .ex_rd       (ex_rd),
  .ex_wen      (ex_wen),
  .ex_is_load  (ex_is_load),
  .mem_rd      (mem_rd),
  .mem_wen     (mem_wen),
  .mul_busy    (mul_busy),
  .ct_busy     (ct_busy),
  .front_hold  (front_hold),
  .dx_bubble   (dx_bubble),
  .opa_sel     (opa_sel),
  .opb_sel     (opb_sel)
);

// File: tb/hzd_interlock_test.sv
`timescale 1ns/1ps
module hzd_interlock_test;
  localparam int CTN = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ct_mode;
  logic [4:0] dec_rs1, dec_rs2, ex_rd, mem_rd;
  logic dec_rs1_vld, dec_rs2_vld, ex_wen, ex_is_load, mem_wen, mul_busy;
  logic front_hold, dx_bubble;
  logic [1:0] opa_sel, opb_sel;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hzd_interlock #(.AW(5), .CT_STALLS(CTN)) uut (
    .clk(clk), .rst_n(rst_n), .ct_mode(ct_mode),
    .dec_rs1(dec_rs1), .dec_rs1_vld(dec_rs1_vld),
    .dec_rs2(dec_rs2), .dec_rs2_vld(dec_rs2_vld),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mul_busy(mul_busy),
    .front_hold(front_hold), .dx_bubble(dx_bubble),
    .opa_sel(opa_sel), .opb_sel(opb_sel)
  );

  typedef struct packed {
    logic [7:0] req;
    logic [4:0] rs1; logic v1;
    logic [4:0] rs2; logic v2;
    logic [4:0] erd; logic ew; logic el;
    logic [4:0] mrd; logic mw;
    logic mul;
    logic st; logic [1:0] fa; logic [1:0] fb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{8'd4, 5'd3,1'b1, 5'd4,1'b1, 5'd3,1'b1,1'b0, 5'd9,1'b0, 1'b0, 1'b0,2'b10,2'b00}, // R4 ex ALU fwd
    '{8'd5, 5'd1,1'b1, 5'd7,1'b1, 5'd2,1'b1,1'b0, 5'd7,1'b1, 1'b0, 1'b0,2'b00,2'b01}, // R5 mem fwd
    '{8'd6, 5'd5,1'b1, 5'd2,1'b1, 5'd5,1'b1,1'b0, 5'd5,1'b1, 1'b0, 1'b0,2'b10,2'b00}, // R6 priority
    '{8'd3, 5'd6,1'b1, 5'd2,1'b1, 5'd6,1'b1,1'b1, 5'd9,1'b0, 1'b0, 1'b1,2'b00,2'b00}, // R3 load rs1
    '{8'd3, 5'd1,1'b1, 5'd6,1'b1, 5'd6,1'b1,1'b1, 5'd9,1'b0, 1'b0, 1'b1,2'b00,2'b00}, // R3 load rs2
    '{8'd5, 5'd9,1'b1, 5'd2,1'b1, 5'd3,1'b0,1'b0, 5'd9,1'b1, 1'b0, 1'b0,2'b01,2'b00}, // R5 load in mem
    '{8'd1, 5'd0,1'b1, 5'd2,1'b1, 5'd0,1'b1,1'b1, 5'd9,1'b0, 1'b0, 1'b0,2'b00,2'b00}, // R1 zero vs ex load
    '{8'd1, 5'd1,1'b1, 5'd0,1'b1, 5'd3,1'b0,1'b0, 5'd0,1'b1, 1'b0, 1'b0,2'b00,2'b00}, // R1 zero vs mem
    '{8'd2, 5'd6,1'b0, 5'd2,1'b1, 5'd6,1'b1,1'b1, 5'd9,1'b0, 1'b0, 1'b0,2'b00,2'b00}, // R2 invalid src
    '{8'd7, 5'd6,1'b1, 5'd2,1'b1, 5'd6,1'b0,1'b1, 5'd6,1'b0, 1'b0, 1'b0,2'b00,2'b00}, // R7 no write
    '{8'd8, 5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b0,1'b0, 5'd4,1'b0, 1'b1, 1'b1,2'b00,2'b00}, // R8 mul busy
    '{8'd4, 5'd8,1'b1, 5'd8,1'b1, 5'd8,1'b1,1'b0, 5'd4,1'b1, 1'b0, 1'b0,2'b10,2'b10}, // R4 both operands
    '{8'd12,5'd1,1'b1, 5'd2,1'b1, 5'd3,1'b1,1'b0, 5'd4,1'b1, 1'b0, 1'b0,2'b00,2'b00}  // R12 independent
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ct_mode = 1'b0; mul_busy = 1'b0;
    dec_rs1 = 5'd1; dec_rs1_vld = 1'b1; dec_rs2 = 5'd2; dec_rs2_vld = 1'b1;
    ex_rd = 5'd0; ex_wen = 1'b0; ex_is_load = 1'b0;
    mem_rd = 5'd0; mem_wen = 1'b0;
  endtask

  task automatic alu_dep();
    ex_rd = 5'd1; ex_wen = 1'b1; ex_is_load = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R11 hold in reset", int'(front_hold), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 hold after reset", int'(front_hold), 0);
    check("R12 bubble after reset", int'(dx_bubble), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ct_mode = 1'b0;
      dec_rs1 = TBL[i].rs1; dec_rs1_vld = TBL[i].v1;
      dec_rs2 = TBL[i].rs2; dec_rs2_vld = TBL[i].v2;
      ex_rd = TBL[i].erd; ex_wen = TBL[i].ew; ex_is_load = TBL[i].el;
      mem_rd = TBL[i].mrd; mem_wen = TBL[i].mw; mul_busy = TBL[i].mul;
      #1;
      check($sformatf("R%0d row %0d hold", TBL[i].req, i), int'(front_hold), int'(TBL[i].st));
      check($sformatf("R%0d row %0d bubble", TBL[i].req, i), int'(dx_bubble), int'(TBL[i].st));
      check($sformatf("R%0d row %0d opa", TBL[i].req, i), int'(opa_sel), int'(TBL[i].fa));
      check($sformatf("R%0d row %0d opb", TBL[i].req, i), int'(opb_sel), int'(TBL[i].fb));
    end

    // R8: multiply busy across several cycles, then release
    @(negedge clk); idle(); mul_busy = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1; check("R8 mul busy hold", int'(front_hold), 1);
      @(negedge clk);
    end
    mul_busy = 1'b0; #1;
    check("R8 mul released", int'(front_hold), 0);

    // R9: ALU dependency in constant-time mode stalls CTN cycles
    @(negedge clk); idle(); ct_mode = 1'b1; alu_dep(); #1;
    check("R9 ct fire on ALU dep", int'(front_hold), 1);
    check("R4 ct keeps forward select", int'(opa_sel), 2);
    // R10: inputs and mode dropped during the window
    @(negedge clk); idle(); #1;
    check("R10 window continues", int'(front_hold), 1);
    @(negedge clk); #1;
    check("R9 window length", int'(front_hold), 0);

    // R9/R10: hazard held steady re-arms only after a full window
    @(negedge clk); idle(); ct_mode = 1'b1; mem_rd = 5'd2; mem_wen = 1'b1;
    for (int c = 0; c < 2 * CTN; c++) begin
      #1; check("R9 steady hazard hold", int'(front_hold), 1);
      @(negedge clk);
    end
    idle(); ct_mode = 1'b1; #1;
    // window that started in cycle 2*CTN-CTN has ended exactly here
    check("R10 no early rearm", int'(front_hold), 0);

    // R9: multiply in constant-time mode
    @(negedge clk); idle(); ct_mode = 1'b1; mul_busy = 1'b1; #1;
    check("R9 ct mul fire", int'(front_hold), 1);
    @(negedge clk); mul_busy = 1'b0; #1;
    check("R9 ct mul second cycle", int'(front_hold), 1);
    @(negedge clk); #1;
    check("R9 ct mul end", int'(front_hold), 0);

    // R1 in constant-time mode: zero register never fires
    @(negedge clk); idle(); ct_mode = 1'b1; dec_rs1 = 5'd0; ex_rd = 5'd0; ex_wen = 1'b1; #1;
    check("R1 ct zero no fire", int'(front_hold), 0);

    // R11: reset in the middle of a window
    @(negedge clk); idle(); ct_mode = 1'b1; alu_dep(); #1;
    check("R9 fire before reset", int'(front_hold), 1);
    @(negedge clk); idle(); rst_n = 1'b0; #1;
    check("R11 reset clears window", int'(front_hold), 0);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R11 idle after reset", int'(front_hold), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule